// File: doc/BRIEF.md
# DES Single-Round Step Unit

This block performs one round of the Data Encryption Standard each time it is strobed. An outside sequencer holds the running 64-bit data word and the running key word. It presents them together with a round index 0..15 and an encrypt/decrypt select, pulses the step strobe, and gets back the updated words one clock later. Sixteen such calls, with the outputs fed back as the next inputs, encrypt or decrypt one 8-byte block under an 8-byte key.

On index 0 the unit takes the raw data block and the raw 64-bit key. It applies the initial permutation to the data and the 56-bit key selection to the key. On indices 1..15 it expects the words it returned on the previous call. The returned key word carries the two 28-bit key halves in its low 56 bits and zeros in its top byte. On index 15 the unit swaps the halves and applies the final permutation, so the data output of that call is the finished block.

In the encrypt direction the key halves are rotated left before the subkey is taken from them. In the decrypt direction the subkey is taken first and the halves are then rotated right. This gives the reversed subkey order with no extra storage.

Top module: `des_round_step`

## Requirements
- R1: Sixteen encrypt steps on the standard known-answer pairs give the expected block: key 133457799BBCDFF1 with 0123456789ABCDEF gives 85E813540F0AB405, and key 0E329232EA6D0D73 with 8787878787878787 gives 0000000000000000.
- R2: Sixteen decrypt steps on those ciphertexts under the same keys return the original plaintexts.
- R3: For arbitrary data and keys, an encrypt pass followed by a decrypt pass returns the original data.
- R4: valid_o is high in exactly the cycle after a cycle with step_i high, and low otherwise.
- R5: For round indices 1 to 14, bits [63:32] of data_o equal bits [31:0] of the data_i presented with the step.
- R6: key_o[63:56] is zero after every step. After a full pass, key_o is the same whether the direction was encrypt or decrypt.
- R7: While step_i is low, data_o and key_o hold their values whatever the other inputs do.
- R8: While reset is asserted and until the first step, data_o and key_o are zero and valid_o is low.
- R9: On an encrypt step with index 1..15, each 28-bit key half (C in key_i[55:28], D in key_i[27:0]) is rotated left by 1 for indices 1, 8 and 15 and by 2 for the other indices.
- R10: On a decrypt step with index 1..15, each key half is rotated right by the encrypt rotation amount of index 15 minus the step index. That amount is 1 for decrypt indices 7, 14 and 15 and 2 for the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_i | input | 1 | Perform one round this cycle |
| decrypt_i | input | 1 | 1 = decrypt direction, 0 = encrypt |
| round_i | input | 4 | Round index 0..15 |
| data_i | input | 64 | Data word (raw block on index 0) |
| key_i | input | 64 | Key word (raw key on index 0, key halves in [55:0] otherwise) |
| data_o | output | 64 | Updated data word (finished block after index 15) |
| key_o | output | 64 | Updated key halves in [55:0], zero top byte |
| valid_o | output | 1 | Outputs updated by the previous cycle's step |

## Verification
An error in an S-box entry, a permutation position or the subkey selection stays hidden inside a single round. It shows at the ports only when a full pass ends, as a wrong finished block, so the known-answer runs catch it after sixteen steps. A wrong rotation amount or direction shows in key_o immediately, in the cycle after the affected step. A broken half swap shows in data_o[63:32] on the next middle round. A misplaced rotation in the decrypt direction still passes every single-step check, and shows only when the decrypt pass fails to restore the plaintext.

// File: rtl/des_step_pkg.sv
package des_step_pkg;

  localparam int BLK_W  = 64;
  localparam int HALF_W = BLK_W / 2;
  localparam int CD_W   = 56;
  localparam int KH_W   = CD_W / 2;
  localparam int SUB_W  = 48;
  localparam int RND_W  = 4;
  localparam int N_SBOX = 8;
  localparam logic [RND_W-1:0] LAST_RND = '1;

  // S-box contents, row-major (row 0 first), one nibble per entry
  localparam logic [255:0] SBOX_TAB [N_SBOX] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
  };

  // Source bit (1-based, MSB first) of output position i of the initial permutation
  function automatic int ip_src(input int i);
    int r, c;
    r = i / 8;
    c = i % 8;
    if (r < 4) return 58 + 2 * r - 8 * c;
    else       return 57 + 2 * (r - 4) - 8 * c;
  endfunction

  function automatic logic [BLK_W-1:0] init_perm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-ip_src(i)];
    return y;
  endfunction

  function automatic logic [BLK_W-1:0] final_perm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-ip_src(i)] = x[BLK_W-1-i];
    return y;
  endfunction

  // 56-bit key selection, C half then D half
  function automatic logic [CD_W-1:0] key_select(input logic [BLK_W-1:0] k);
    logic [CD_W-1:0] cd;
    int g, m, src;
    for (int i = 0; i < KH_W; i++) begin
      g = i / 8;
      m = i % 8;
      src = 57 + g - 8 * m;
      cd[CD_W-1-i] = k[BLK_W-src];
      if (g < 3) src = 63 - g - 8 * m;
      else       src = 28 - 8 * m;
      cd[KH_W-1-i] = k[BLK_W-src];
    end
    return cd;
  endfunction

  function automatic int sub_src(input int i);
    case (i)
      0: return 14;  1: return 17;  2: return 11;  3: return 24;
      4: return 1;   5: return 5;   6: return 3;   7: return 28;
      8: return 15;  9: return 6;  10: return 21; 11: return 10;
      12: return 23; 13: return 19; 14: return 12; 15: return 4;
      16: return 26; 17: return 8;  18: return 16; 19: return 7;
      20: return 27; 21: return 20; 22: return 13; 23: return 2;
      24: return 41; 25: return 52; 26: return 31; 27: return 37;
      28: return 47; 29: return 55; 30: return 30; 31: return 40;
      32: return 51; 33: return 45; 34: return 33; 35: return 48;
      36: return 44; 37: return 49; 38: return 39; 39: return 56;
      40: return 34; 41: return 53; 42: return 46; 43: return 42;
      44: return 50; 45: return 36; 46: return 29; default: return 32;
    endcase
  endfunction

  function automatic logic [SUB_W-1:0] subkey_pick(input logic [CD_W-1:0] cd);
    logic [SUB_W-1:0] k;
    for (int i = 0; i < SUB_W; i++) k[SUB_W-1-i] = cd[CD_W-sub_src(i)];
    return k;
  endfunction

  function automatic logic [SUB_W-1:0] expand(input logic [HALF_W-1:0] r);
    logic [SUB_W-1:0] e;
    int src;
    for (int j = 0; j < 8; j++) begin
      for (int m = 0; m < 6; m++) begin
        src = 4 * j + m;
        if (src == 0)  src = 32;
        if (src == 33) src = 1;
        e[SUB_W-1-(6*j+m)] = r[HALF_W-src];
      end
    end
    return e;
  endfunction

  function automatic int pp_src(input int i);
    case (i)
      0: return 16;  1: return 7;   2: return 20;  3: return 21;
      4: return 29;  5: return 12;  6: return 28;  7: return 17;
      8: return 1;   9: return 15; 10: return 23; 11: return 26;
      12: return 5;  13: return 18; 14: return 31; 15: return 10;
      16: return 2;  17: return 8;  18: return 24; 19: return 14;
      20: return 32; 21: return 27; 22: return 3;  23: return 9;
      24: return 19; 25: return 13; 26: return 30; 27: return 6;
      28: return 22; 29: return 11; 30: return 4;  default: return 25;
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] p_perm(input logic [HALF_W-1:0] s);
    logic [HALF_W-1:0] y;
    for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = s[HALF_W-pp_src(i)];
    return y;
  endfunction

  // Rotation amount of the encrypt schedule for a given index
  function automatic logic [1:0] rot_amt(input logic [RND_W-1:0] r);
    if (r == 4'd0 || r == 4'd1 || r == 4'd8 || r == 4'd15) return 2'd1;
    else return 2'd2;
  endfunction

endpackage

// File: rtl/des_rst_sync.sv
module des_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/des_key_sched.sv
module des_key_sched
  import des_step_pkg::*;
(
  input  logic [RND_W-1:0] round_i,
  input  logic             decrypt_i,
  input  logic [BLK_W-1:0] key_i,
  output logic [SUB_W-1:0] subkey_o,
  output logic [CD_W-1:0]  cd_next_o
);
  logic [CD_W-1:0] cd_in;
  logic [KH_W-1:0] c_in, d_in, c_l, d_l, c_r, d_r;
  logic [1:0]      amt_enc, amt_dec;
  logic [CD_W-1:0] cd_enc, cd_dec;

  always_comb begin
    if (round_i == '0) cd_in = key_select(key_i);
    else               cd_in = key_i[CD_W-1:0];
    c_in = cd_in[CD_W-1:KH_W];
    d_in = cd_in[KH_W-1:0];
    amt_enc = rot_amt(round_i);
    amt_dec = rot_amt(LAST_RND - round_i);

    if (amt_enc == 2'd1) begin
      c_l = {c_in[KH_W-2:0], c_in[KH_W-1]};
      d_l = {d_in[KH_W-2:0], d_in[KH_W-1]};
    end else begin
      c_l = {c_in[KH_W-3:0], c_in[KH_W-1:KH_W-2]};
      d_l = {d_in[KH_W-3:0], d_in[KH_W-1:KH_W-2]};
    end

    if (amt_dec == 2'd1) begin
      c_r = {c_in[0], c_in[KH_W-1:1]};
      d_r = {d_in[0], d_in[KH_W-1:1]};
    end else begin
      c_r = {c_in[1:0], c_in[KH_W-1:2]};
      d_r = {d_in[1:0], d_in[KH_W-1:2]};
    end

    cd_enc = {c_l, d_l};
    cd_dec = {c_r, d_r};

    // encrypt: rotate then use; decrypt: use then rotate
    if (decrypt_i) begin
      subkey_o  = subkey_pick(cd_in);
      cd_next_o = cd_dec;
    end else begin
      subkey_o  = subkey_pick(cd_enc);
      cd_next_o = cd_enc;
    end
  end
endmodule

// File: rtl/des_f_func.sv
module des_f_func
  import des_step_pkg::*;
(
  input  logic [HALF_W-1:0] r_i,
  input  logic [SUB_W-1:0]  subkey_i,
  output logic [HALF_W-1:0] f_o
);
  logic [SUB_W-1:0]  mixed;
  logic [HALF_W-1:0] sub_out;

  assign mixed = expand(r_i) ^ subkey_i;

  for (genvar g = 0; g < N_SBOX; g++) begin : g_sbox
    logic [5:0] six;
    logic [5:0] idx;
    assign six = mixed[SUB_W-1-6*g -: 6];
    assign idx = {six[5], six[0], six[4:1]};
    assign sub_out[HALF_W-1-4*g -: 4] = SBOX_TAB[g][255 - 4*idx -: 4];
  end

  assign f_o = p_perm(sub_out);
endmodule

// File: rtl/des_round_step.sv
module des_round_step
  import des_step_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_i,
  input  logic        decrypt_i,
  input  logic [3:0]  round_i,
  input  logic [63:0] data_i,
  input  logic [63:0] key_i,
  output logic [63:0] data_o,
  output logic [63:0] key_o,
  output logic        valid_o
);
  logic rst_int_n;

  logic [BLK_W-1:0]  blk_in;
  logic [HALF_W-1:0] left_h, right_h, f_val, new_right;
  logic [SUB_W-1:0]  subkey;
  logic [CD_W-1:0]   cd_next;
  logic [BLK_W-1:0]  blk_out;

  logic [BLK_W-1:0] data_d, data_q;
  logic [BLK_W-1:0] key_d, key_q;
  logic             valid_d, valid_q;

  des_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  des_key_sched u_ks (
    .round_i   (round_i),
    .decrypt_i (decrypt_i),
    .key_i     (key_i),
    .subkey_o  (subkey),
    .cd_next_o (cd_next)
  );

  always_comb begin
    if (round_i == '0) blk_in = init_perm(data_i);
    else               blk_in = data_i;
    left_h  = blk_in[BLK_W-1:HALF_W];
    right_h = blk_in[HALF_W-1:0];
  end

  des_f_func u_f (
    .r_i      (right_h),
    .subkey_i (subkey),
    .f_o      (f_val)
  );

  always_comb begin
    new_right = left_h ^ f_val;
    if (round_i == LAST_RND) blk_out = final_perm({new_right, right_h});
    else                     blk_out = {right_h, new_right};
  end

  // next-state
  always_comb begin
    valid_d = step_i;
    if (step_i) begin
      data_d = blk_out;
      key_d  = {{(BLK_W-CD_W){1'b0}}, cd_next};
    end else begin
      data_d = data_q;
      key_d  = key_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      data_q  <= '0;
      key_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      key_q   <= key_d;
      valid_q <= valid_d;
    end
  end

  assign data_o  = data_q;
  assign key_o   = key_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/des_round_step_chk.sv
module des_round_step_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step_i,
  input logic        decrypt_i,
  input logic [3:0]  round_i,
  input logic [63:0] data_i,
  input logic [63:0] key_i,
  input logic [63:0] data_o,
  input logic [63:0] key_o,
  input logic        valid_o
);
  // R4
  a_r4_valid_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> valid_o);
  a_r4_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> !valid_o);

  // R5
  a_r5_half_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && round_i != 4'd0 && round_i != 4'd15)
      |=> data_o[63:32] == $past(data_i[31:0]));

  // R6
  a_r6_key_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> key_o[63:56] == 8'h00);

  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> ($stable(data_o) && $stable(key_o)));

  // R9
  a_r9_enc_rot: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !decrypt_i && round_i != 4'd0)
      |=> (key_o[55:28] == {$past(key_i[54:28]), $past(key_i[55])}) ||
          (key_o[55:28] == {$past(key_i[53:28]), $past(key_i[55:54])}));

  // R10
  a_r10_dec_rot: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && decrypt_i && round_i != 4'd0)
      |=> (key_o[27:0] == {$past(key_i[0]), $past(key_i[27:1])}) ||
          (key_o[27:0] == {$past(key_i[1:0]), $past(key_i[27:2])}));
endmodule

bind des_round_step des_round_step_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_i    (step_i),
  .decrypt_i (decrypt_i),
  .round_i   (round_i),
  .data_i    (data_i),
  .key_i     (key_i),
  .data_o    (data_o),
  .key_o     (key_o),
  .valid_o   (valid_o)
);

// File: tb/tb_des_round_step.sv
`timescale 1ns/1ps
module tb_des_round_step;
  logic        clk;
  logic        rst_n;
  logic        step_i;
  logic        decrypt_i;
  logic [3:0]  round_i;
  logic [63:0] data_i;
  logic [63:0] key_i;
  logic [63:0] data_o;
  logic [63:0] key_o;
  logic        valid_o;

  int checks;
  int failures;
  bit done;

  // scoreboard: expected data, data mask, expected key, key mask
  logic [255:0] sb_q[$];
  string        tag_q[$];

  des_round_step dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .decrypt_i(decrypt_i),
    .round_i(round_i), .data_i(data_i), .key_i(key_i),
    .data_o(data_o), .key_o(key_o), .valid_o(valid_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (sb_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R4 actual=unexpected valid expected=no result");
      end else begin
        logic [255:0] it;
        string tg;
        it = sb_q.pop_front();
        tg = tag_q.pop_front();
        if (it[191:128] != 64'h0) check64(tg, data_o & it[191:128], it[255:192]);
        if (it[63:0]    != 64'h0) check64({tg, "/R6"}, key_o & it[63:0], it[127:64]);
      end
    end
  end

  task automatic one_step(input bit dec, input logic [3:0] r, input logic [63:0] d,
                          input logic [63:0] k, input logic [63:0] ed, input logic [63:0] dm,
                          input logic [63:0] ek, input logic [63:0] km, input string tg);
    @(negedge clk);
    sb_q.push_back({ed, dm, ek, km});
    tag_q.push_back(tg);
    step_i = 1'b1; decrypt_i = dec; round_i = r; data_i = d; key_i = k;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic run_block(input bit dec, input logic [63:0] din, input logic [63:0] kin,
                           input bit chk_d, input logic [63:0] exp_d,
                           input bit chk_k, input logic [63:0] exp_k, input string tg,
                           output logic [63:0] dout, output logic [63:0] kout);
    logic [63:0] d, k, ed, dm, ek, km;
    d = din; k = kin;
    for (int r = 0; r < 16; r++) begin
      ed = '0; dm = '0; ek = '0; km = 64'hFF00_0000_0000_0000;
      if (r >= 1 && r <= 14) begin
        ed = {d[31:0], 32'h0}; dm = 64'hFFFF_FFFF_0000_0000;
      end
      if (r == 15 && chk_d) begin ed = exp_d; dm = '1; end
      if (r == 15 && chk_k) begin ek = exp_k; km = '1; end
      one_step(dec, r[3:0], d, k, ed, dm, ek, km, (r >= 1 && r <= 14) ? "R5" : tg);
      d = data_o; k = key_o;
    end
    dout = d; kout = k;
  endtask

  initial begin
    logic [63:0] ct, kf_e, kf_d, pt, key, hold_d, hold_k;
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; step_i = 1'b0; decrypt_i = 1'b0; round_i = '0; data_i = '0; key_i = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check64("R8", data_o, 64'h0);
    check64("R8", key_o, 64'h0);
    check64("R8", {63'h0, valid_o}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check64("R8", data_o, 64'h0);
    check64("R8", {63'h0, valid_o}, 64'h0);

    // R1 known answers
    run_block(1'b0, 64'h0123456789ABCDEF, 64'h133457799BBCDFF1, 1'b1, 64'h85E813540F0AB405,
              1'b0, 64'h0, "R1", ct, kf_e);
    run_block(1'b1, 64'h85E813540F0AB405, 64'h133457799BBCDFF1, 1'b1, 64'h0123456789ABCDEF,
              1'b1, kf_e, "R2", pt, kf_d);
    run_block(1'b0, 64'h8787878787878787, 64'h0E329232EA6D0D73, 1'b1, 64'h0,
              1'b0, 64'h0, "R1", ct, kf_e);
    run_block(1'b1, 64'h0, 64'h0E329232EA6D0D73, 1'b1, 64'h8787878787878787,
              1'b1, kf_e, "R2", pt, kf_d);

    // R7 hold while idle, inputs churning
    repeat (2) @(negedge clk);
    hold_d = data_o; hold_k = key_o;
    for (int i = 0; i < 3; i++) begin
      decrypt_i = ~decrypt_i; round_i = round_i + 4'd5;
      data_i = {$urandom, $urandom}; key_i = {$urandom, $urandom};
      @(negedge clk);
      check64("R7", data_o, hold_d);
      check64("R7", key_o, hold_k);
      check64("R4", {63'h0, valid_o}, 64'h0);
    end

    // R3 round trips
    for (int n = 0; n < 4; n++) begin
      pt  = {$urandom, $urandom};
      key = {$urandom, $urandom};
      run_block(1'b0, pt, key, 1'b0, 64'h0, 1'b0, 64'h0, "R3", ct, kf_e);
      run_block(1'b1, ct, key, 1'b1, pt, 1'b1, kf_e, "R3", hold_d, kf_d);
    end

    // R9 encrypt rotation: C=1, D=0x8000000
    one_step(1'b0, 4'd1, 64'h0, {8'h0, 28'h0000001, 28'h8000000}, 64'h0, 64'h0,
             {8'h0, 28'h0000002, 28'h0000001}, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    one_step(1'b0, 4'd2, 64'h0, {8'h0, 28'h0000001, 28'h8000000}, 64'h0, 64'h0,
             {8'h0, 28'h0000004, 28'h0000002}, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    one_step(1'b0, 4'd8, 64'h0, {8'h0, 28'h0000001, 28'h8000000}, 64'h0, 64'h0,
             {8'h0, 28'h0000002, 28'h0000001}, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    // R10 decrypt rotation
    one_step(1'b1, 4'd1, 64'h0, {8'h0, 28'h0000001, 28'h8000000}, 64'h0, 64'h0,
             {8'h0, 28'h4000000, 28'h2000000}, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
    one_step(1'b1, 4'd7, 64'h0, {8'h0, 28'h0000001, 28'h8000000}, 64'h0, 64'h0,
             {8'h0, 28'h8000000, 28'h4000000}, 64'hFFFF_FFFF_FFFF_FFFF, "R10");

    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R4 actual=%0d pending expected=0", sb_q.size());
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule